// File: doc/BRIEF.md
# Software-Triggered Reset Sequencer

This block lets software pull reset pulses on demand. One write on the fast master clock can ask for any mix of three actions: a processor reset, a peripheral reset, and a low pulse on an active-low external reset pad. At least one action must be set for anything to happen. Internal reset outputs drop in the master-clock cycle after the write is sampled. All pulse timing runs on a separate slow clock, and each release crosses back to the master clock through a synchronizer.

While a command is in flight, a busy flag is high and further writes are ignored. A cause field records a software reset only when the processor action was part of the command. The pad pulse length comes from a small length-select input. The pad input is resynchronized to the slow clock. When user-reset detection is enabled, a low pad starts a user reset, but not while the block is driving the pad low itself.

Top module: `swrst_sequencer`

## Requirements
- R1: A write (`wr_en` high at a master-clock edge) with at least one of `wr_proc`, `wr_periph`, `wr_ext` set, while idle, starts a command, and `sw_busy` reads 1 after that edge. A write with all three bits at 0 starts nothing.
- R2: `proc_rst_n` (when `wr_proc`) and `periph_rst_n` (when `wr_periph`) go low on the master-clock edge that accepts the command.
- R3: Internal software resets last three slow-clock cycles. The count starts on the third slow edge after acceptance. The outputs return high on the third master-clock edge after the slow edge that ends the count.
- R4: `sw_busy` stays high until both the internal count and any pad pulse have finished. It clears on the third master-clock edge after the slow edge where the later of the two ends.
- R5: Writes while `sw_busy` is high have no effect: no reset, no cause change, no new pulse.
- R6: `rst_cause` is 0 after reset. It becomes 3 (software) on acceptance of a command that includes `wr_proc`. Other commands leave it unchanged.
- R7: With `wr_ext`, `pad_out_n` is low for exactly 2^(`ext_len`+1) slow-clock cycles, starting on the third slow edge after acceptance. Without `wr_ext`, `pad_out_n` stays high.
- R8: The block's own pad pulse, seen back on `pad_in`, never starts a user reset, even with `usr_en` at 1.
- R9: With `usr_en` at 1, a low on `pad_in` captured by two slow-clock flops drives `proc_rst_n` and `periph_rst_n` low from the next slow edge. They are released in the same way after the pad returns high. With `usr_en` at 0, a low pad has no effect.
- R10: A user reset sets `rst_cause` to 4 on the third master-clock edge after the slow edge where the user reset begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mck | input | 1 | Master clock for command writes and status |
| slck | input | 1 | Slow clock for pulse timing and pad sampling |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| wr_en | input | 1 | Command write strobe (master clock) |
| wr_proc | input | 1 | Command bit: processor reset |
| wr_periph | input | 1 | Command bit: peripheral reset |
| wr_ext | input | 1 | Command bit: pad pulse |
| ext_len | input | LEN_W | Pad pulse length select, pulse = 2^(ext_len+1) slow cycles |
| usr_en | input | 1 | Enables user reset from a low pad |
| pad_in | input | 1 | Reset pad level as seen from outside |
| pad_out_n | output | 1 | Active-low pad drive |
| proc_rst_n | output | 1 | Active-low processor reset |
| periph_rst_n | output | 1 | Active-low peripheral reset |
| sw_busy | output | 1 | Command in progress; writes ignored |
| rst_cause | output | 3 | Last recorded cause: 0 none, 3 software, 4 user |

## Verification
Commands are issued as periph-only, proc plus pad at the shortest length, pad-only at a mid length, and all three bits at the longest length. Together these separate the case where the internal count finishes last from the case where the pad pulse does, and show whether the cause field follows the processor bit alone. An all-zero write and a write landing one cycle into a busy period show that only qualified idle writes start a sequence. A pad held low with detection disabled, then with it enabled, and the block's own echoed pulse with detection enabled, separate a real user reset from a self-caused one.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_SOFT = 3'd3,
        CAUSE_USER = 3'd4
    } cause_e;

    localparam int EV_INT = 0;
    localparam int EV_ALL = 1;
    localparam int EV_USR = 2;
    localparam int EV_NUM = 3;

endpackage

// File: rtl/swrst_tsync.sv
module swrst_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pulse = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/swrst_cmd.sv
module swrst_cmd import swrst_pkg::*; #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             c_proc,
    input  logic             c_periph,
    input  logic             c_ext,
    input  logic [LEN_W-1:0] len_sel,
    input  logic             int_rel,
    input  logic             all_rel,
    input  logic             usr_evt,
    output logic             busy,
    output logic             proc_hold,
    output logic             periph_hold,
    output logic             req_tgl,
    output logic             ext_go,
    output logic [LEN_W-1:0] len_q,
    output logic [2:0]       cause
);
    typedef struct packed {
        logic             busy;
        logic             proc;
        logic             periph;
        logic             ext;
        logic             tgl;
        logic [LEN_W-1:0] len;
        cause_e           cause;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d   = st_q;
        accept = wr && (c_proc || c_periph || c_ext) && !st_q.busy;
        if (int_rel) begin
            st_d.proc   = 1'b0;
            st_d.periph = 1'b0;
        end
        if (all_rel) st_d.busy  = 1'b0;
        if (usr_evt) st_d.cause = CAUSE_USER;
        if (accept) begin
            st_d.busy   = 1'b1;
            st_d.proc   = c_proc;
            st_d.periph = c_periph;
            st_d.ext    = c_ext;
            st_d.len    = len_sel;
            st_d.tgl    = ~st_q.tgl;
            if (c_proc) st_d.cause = CAUSE_SOFT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, proc: 1'b0, periph: 1'b0, ext: 1'b0, tgl: 1'b0,
                      len: '0, cause: CAUSE_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign proc_hold   = st_q.proc;
    assign periph_hold = st_q.periph;
    assign req_tgl     = st_q.tgl;
    assign ext_go      = st_q.ext;
    assign len_q       = st_q.len;
    assign cause       = st_q.cause;

    assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st_q.busy);

    assert_proc_asserts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && c_proc) |=> proc_hold);

    assert_soft_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && c_proc) |=> (st_q.cause == CAUSE_SOFT));

    assert_locked_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && wr && c_proc && !usr_evt) |=> $stable(st_q.cause));
endmodule

// File: rtl/swrst_timer.sv
module swrst_timer #(
    parameter int LEN_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int INT_SLOW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_pulse,
    input  logic             ext_go,
    input  logic [LEN_W-1:0] len_q,
    input  logic             user_en,
    input  logic             pin_in,
    output logic             int_tgl,
    output logic             all_tgl,
    output logic             usr_tgl,
    output logic             usr_active,
    output logic             pin_out_n
);
    localparam int IW    = $clog2(INT_SLOW + 1);
    localparam int CNT_W = (1 << LEN_W) + 1;
    localparam int TW    = $clog2(SYNC_STAGES + 1);
    localparam logic [LEN_W:0] SH_ONE = 1;

    typedef struct packed {
        logic [IW-1:0]          icnt;
        logic [CNT_W-1:0]       ecnt;
        logic [TW-1:0]          tail;
        logic [SYNC_STAGES-1:0] pin;
        logic                   usr;
        logic                   int_t;
        logic                   all_t;
        logic                   usr_t;
    } tmr_st_t;

    tmr_st_t          st_d, st_q;
    logic             mask;
    logic [CNT_W-1:0] ecnt_load;

    always_comb begin
        st_d      = st_q;
        ecnt_load = CNT_W'(1) << ({1'b0, len_q} + SH_ONE);
        st_d.pin  = {st_q.pin[SYNC_STAGES-2:0], pin_in};
        mask      = (st_q.ecnt != '0) || (st_q.tail != '0);
        st_d.usr  = user_en && !st_q.pin[SYNC_STAGES-1] && !mask;
        if (st_d.usr && !st_q.usr) st_d.usr_t = ~st_q.usr_t;
        if (req_pulse) begin
            st_d.icnt = IW'(INT_SLOW);
            st_d.ecnt = ext_go ? ecnt_load : '0;
        end else begin
            if (st_q.icnt != '0) begin
                st_d.icnt = st_q.icnt - IW'(1);
                if (st_q.icnt == IW'(1)) st_d.int_t = ~st_q.int_t;
            end
            if (st_q.ecnt != '0) begin
                st_d.ecnt = st_q.ecnt - CNT_W'(1);
                if (st_q.ecnt == CNT_W'(1)) st_d.tail = TW'(SYNC_STAGES);
            end else if (st_q.tail != '0) begin
                st_d.tail = st_q.tail - TW'(1);
            end
            if ((st_q.icnt != '0 || st_q.ecnt != '0) && st_d.icnt == '0 && st_d.ecnt == '0)
                st_d.all_t = ~st_q.all_t;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{icnt: '0, ecnt: '0, tail: '0, pin: '1, usr: 1'b0,
                      int_t: 1'b0, all_t: 1'b0, usr_t: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign int_tgl    = st_q.int_t;
    assign all_tgl    = st_q.all_t;
    assign usr_tgl    = st_q.usr_t;
    assign usr_active = st_q.usr;
    assign pin_out_n  = (st_q.ecnt == '0);

    assert_int_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |=> (st_q.icnt == IW'(INT_SLOW)));

    assert_pad_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pulse && ext_go) |=> !pin_out_n);

    assert_self_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ecnt != '0) |=> !st_q.usr);
endmodule

// File: rtl/swrst_sequencer.sv
module swrst_sequencer import swrst_pkg::*; #(
    parameter int LEN_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int INT_SLOW    = 3
) (
    input  logic             mck,
    input  logic             slck,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_proc,
    input  logic             wr_periph,
    input  logic             wr_ext,
    input  logic [LEN_W-1:0] ext_len,
    input  logic             usr_en,
    input  logic             pad_in,
    output logic             pad_out_n,
    output logic             proc_rst_n,
    output logic             periph_rst_n,
    output logic             sw_busy,
    output logic [2:0]       rst_cause
);
    logic              proc_hold, periph_hold, req_tgl, ext_go, req_pulse, usr_active;
    logic [LEN_W-1:0]  len_q;
    logic [EV_NUM-1:0] ev_tgl, ev_pulse;

    swrst_cmd #(.LEN_W(LEN_W)) u_cmd (
        .clk(mck), .rst_n(rst_n), .wr(wr_en),
        .c_proc(wr_proc), .c_periph(wr_periph), .c_ext(wr_ext), .len_sel(ext_len),
        .int_rel(ev_pulse[EV_INT]), .all_rel(ev_pulse[EV_ALL]), .usr_evt(ev_pulse[EV_USR]),
        .busy(sw_busy), .proc_hold(proc_hold), .periph_hold(periph_hold),
        .req_tgl(req_tgl), .ext_go(ext_go), .len_q(len_q), .cause(rst_cause)
    );

    swrst_tsync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(slck), .rst_n(rst_n), .din(req_tgl), .pulse(req_pulse)
    );

    swrst_timer #(.LEN_W(LEN_W), .SYNC_STAGES(SYNC_STAGES), .INT_SLOW(INT_SLOW)) u_timer (
        .clk(slck), .rst_n(rst_n), .req_pulse(req_pulse), .ext_go(ext_go), .len_q(len_q),
        .user_en(usr_en), .pin_in(pad_in),
        .int_tgl(ev_tgl[EV_INT]), .all_tgl(ev_tgl[EV_ALL]), .usr_tgl(ev_tgl[EV_USR]),
        .usr_active(usr_active), .pin_out_n(pad_out_n)
    );

    for (genvar g = 0; g < EV_NUM; g++) begin : g_back
        swrst_tsync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(mck), .rst_n(rst_n), .din(ev_tgl[g]), .pulse(ev_pulse[g])
        );
    end

    assign proc_rst_n   = ~(proc_hold | usr_active);
    assign periph_rst_n = ~(periph_hold | usr_active);
endmodule

// File: tb/swrst_sequencer_test.sv
module swrst_sequencer_test;
    localparam int LEN_W = 3;

    logic mck = 1'b0, slck = 1'b0, rst_n = 1'b1;
    logic wr_en = 1'b0, wr_proc = 1'b0, wr_periph = 1'b0, wr_ext = 1'b0;
    logic [LEN_W-1:0] ext_len = '0;
    logic usr_en = 1'b0, btn_n = 1'b1;
    logic pad_in, pad_out_n, proc_rst_n, periph_rst_n, sw_busy;
    logic [2:0] rst_cause;

    assign pad_in = pad_out_n & btn_n;

    swrst_sequencer #(.LEN_W(LEN_W)) uut (
        .mck(mck), .slck(slck), .rst_n(rst_n), .wr_en(wr_en), .wr_proc(wr_proc),
        .wr_periph(wr_periph), .wr_ext(wr_ext), .ext_len(ext_len), .usr_en(usr_en),
        .pad_in(pad_in), .pad_out_n(pad_out_n), .proc_rst_n(proc_rst_n),
        .periph_rst_n(periph_rst_n), .sw_busy(sw_busy), .rst_cause(rst_cause)
    );

    always #10 mck = ~mck;
    initial begin
        #45;
        forever begin slck = 1'b1; #80; slck = 1'b0; #80; end
    end

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge mck) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // ---------------- behavioural reference model ----------------
    int  m_req_cnt, m_len, m_cause, s_ack, s_age;
    bit  m_busy, m_proc, m_periph, m_ext;
    int  s_int_ev, s_all_ev, s_usr_ev, m_int_seen, m_all_seen, m_usr_seen, ia, aa, ua;
    int  si, se, stail;
    bit  mp1, mp2, susr;

    always @(posedge mck or negedge rst_n) begin : mstep
        bit nb, np, nq; int nc;
        if (!rst_n) begin
            m_req_cnt <= 0; m_len <= 0; m_cause <= 0; m_busy <= 0; m_proc <= 0;
            m_periph <= 0; m_ext <= 0; m_int_seen <= 0; m_all_seen <= 0; m_usr_seen <= 0;
            ia <= 0; aa <= 0; ua <= 0;
        end else begin
            nb = m_busy; np = m_proc; nq = m_periph; nc = m_cause;
            if (ia == 0 && s_int_ev != m_int_seen) begin ia <= 1; m_int_seen <= s_int_ev; end
            else if (ia == 1) ia <= 2; else if (ia == 2) ia <= 0;
            if (aa == 0 && s_all_ev != m_all_seen) begin aa <= 1; m_all_seen <= s_all_ev; end
            else if (aa == 1) aa <= 2; else if (aa == 2) aa <= 0;
            if (ua == 0 && s_usr_ev != m_usr_seen) begin ua <= 1; m_usr_seen <= s_usr_ev; end
            else if (ua == 1) ua <= 2; else if (ua == 2) ua <= 0;
            if (ia == 2) begin np = 0; nq = 0; end
            if (aa == 2) nb = 0;
            if (ua == 2) nc = 4;
            if (wr_en && (wr_proc || wr_periph || wr_ext) && !m_busy) begin
                nb = 1; np = wr_proc; nq = wr_periph;
                m_ext <= wr_ext; m_len <= int'(ext_len); m_req_cnt <= m_req_cnt + 1;
                if (wr_proc) nc = 3;
            end
            m_busy <= nb; m_proc <= np; m_periph <= nq; m_cause <= nc;
        end
    end

    always @(posedge slck or negedge rst_n) begin : sstep
        bit msk, nu; int ni, ne;
        if (!rst_n) begin
            s_ack <= 0; s_age <= 0; si <= 0; se <= 0; stail <= 0;
            mp1 <= 1; mp2 <= 1; susr <= 0; s_int_ev <= 0; s_all_ev <= 0; s_usr_ev <= 0;
        end else begin
            mp1 <= (se == 0) && btn_n;
            mp2 <= mp1;
            msk = (se != 0) || (stail != 0);
            nu  = usr_en && !mp2 && !msk;
            if (nu && !susr) s_usr_ev <= s_usr_ev + 1;
            susr <= nu;
            if (s_age == 0 && m_req_cnt != s_ack) begin s_age <= 1; s_ack <= m_req_cnt; end
            else if (s_age == 1) s_age <= 2;
            else if (s_age == 2) s_age <= 0;
            if (s_age == 2) begin
                si <= 3;
                se <= m_ext ? (1 << (m_len + 1)) : 0;
            end else begin
                ni = (si > 0) ? si - 1 : 0;
                ne = (se > 0) ? se - 1 : 0;
                if (si == 1) s_int_ev <= s_int_ev + 1;
                if (se == 1) stail <= 2;
                else if (se == 0 && stail > 0) stail <= stail - 1;
                if ((si != 0 || se != 0) && ni == 0 && ne == 0) s_all_ev <= s_all_ev + 1;
                si <= ni; se <= ne;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge mck) begin
        if ($time > 5) begin
            check(susr ? "R9" : (m_proc ? "R2" : "R3"), "proc_rst_n", int'(proc_rst_n), int'(!(m_proc || susr)));
            check(susr ? "R9" : (m_periph ? "R2" : "R3"), "periph_rst_n", int'(periph_rst_n), int'(!(m_periph || susr)));
            check("R4", "sw_busy", int'(sw_busy), int'(m_busy));
            check("R7", "pad_out_n", int'(pad_out_n), int'(se == 0));
            check(m_cause == 4 ? "R10" : "R6", "rst_cause", int'(rst_cause), m_cause);
        end
    end

    // ---------------- directed stimulus ----------------
    int  pad_low = 0;
    bit  proc_low_seen = 1'b0;
    always @(negedge slck) if (rst_n && !pad_out_n) pad_low++;
    always @(negedge mck) if (rst_n && !proc_rst_n) proc_low_seen = 1'b1;

    task automatic do_write(input bit p, input bit q, input bit e, input int len);
        @(negedge mck);
        wr_en = 1'b1; wr_proc = p; wr_periph = q; wr_ext = e; ext_len = LEN_W'(len);
        @(negedge mck);
        wr_en = 1'b0; wr_proc = 1'b0; wr_periph = 1'b0; wr_ext = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge mck);
        while (sw_busy) @(negedge mck);
        repeat (4) @(negedge slck);
        @(negedge mck);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #40;
        check("R6", "cause at reset", int'(rst_cause), 0);
        check("R4", "busy at reset", int'(sw_busy), 0);
        check("R7", "pad at reset", int'(pad_out_n), 1);
        check("R2", "proc at reset", int'(proc_rst_n), 1);
        #962 rst_n = 1'b1;
        repeat (3) @(negedge slck);

        // R1: empty command
        do_write(1'b0, 1'b0, 1'b0, 0);
        check("R1", "busy after empty write", int'(sw_busy), 0);

        // R1/R2/R5: periph only, then a proc write while busy
        proc_low_seen = 1'b0;
        @(negedge mck);
        wr_en = 1'b1; wr_periph = 1'b1; ext_len = 3'd1;
        @(negedge mck);
        wr_periph = 1'b0; wr_proc = 1'b1;
        check("R1", "busy after periph write", int'(sw_busy), 1);
        check("R2", "periph low", int'(periph_rst_n), 0);
        @(negedge mck);
        wr_en = 1'b0; wr_proc = 1'b0;
        wait_idle();
        check("R5", "cause after locked write", int'(rst_cause), 0);
        check("R5", "proc never asserted", int'(proc_low_seen), 0);
        check("R3", "periph released", int'(periph_rst_n), 1);
        check("R7", "no pad pulse without ext", pad_low, 0);

        // R6/R7: proc + pad, shortest length
        pad_low = 0;
        do_write(1'b1, 1'b0, 1'b1, 0);
        check("R2", "proc low", int'(proc_rst_n), 0);
        check("R6", "cause soft", int'(rst_cause), 3);
        wait_idle();
        check("R7", "pad length len0", pad_low, 2);
        check("R3", "proc released", int'(proc_rst_n), 1);

        // R8: pad only, detection enabled, own pulse echoed back
        usr_en = 1'b1; pad_low = 0; proc_low_seen = 1'b0;
        do_write(1'b0, 1'b0, 1'b1, 2);
        wait_idle();
        repeat (6) @(negedge slck);
        check("R7", "pad length len2", pad_low, 8);
        check("R8", "no user reset from own pulse", int'(proc_low_seen), 0);
        check("R8", "cause unchanged", int'(rst_cause), 3);
        usr_en = 1'b0;

        // R4/R7: all bits, longest length
        pad_low = 0;
        do_write(1'b1, 1'b1, 1'b1, 7);
        @(negedge mck);
        while (!periph_rst_n) @(negedge mck);
        check("R4", "busy held by pad pulse", int'(sw_busy), 1);
        wait_idle();
        check("R7", "pad length len7", pad_low, 256);

        // R9: pad low with detection off
        proc_low_seen = 1'b0;
        @(negedge mck); btn_n = 1'b0;
        repeat (12) @(negedge slck);
        check("R9", "no reset when disabled", int'(proc_low_seen), 0);
        @(negedge mck); btn_n = 1'b1;
        repeat (4) @(negedge slck);

        // R9/R10: pad low with detection on
        @(negedge mck); usr_en = 1'b1; btn_n = 1'b0;
        repeat (6) @(negedge slck);
        check("R9", "proc low on user reset", int'(proc_rst_n), 0);
        check("R9", "periph low on user reset", int'(periph_rst_n), 0);
        check("R10", "cause user", int'(rst_cause), 4);
        @(negedge mck); btn_n = 1'b1;
        repeat (6) @(negedge slck);
        @(negedge mck);
        check("R9", "proc released after pad high", int'(proc_rst_n), 1);
        check("R10", "cause kept", int'(rst_cause), 4);
        usr_en = 1'b0;

        repeat (4) @(negedge mck);
        finish_run();
    end
endmodule